// File: doc/BRIEF.md
# Dual-Channel Peak Detector and Recorder

This block watches two signed sample streams, one carrying line voltage and one carrying line current. Each arrives with its own valid strobe. For each channel it rectifies the sample and compares the upper sixteen bits of the magnitude with a programmable level. Any sample that goes above the level sets a sticky exceeded flag for that channel. A shared interrupt output is raised while a flag is set and that channel's enable is high. One status-read strobe clears both flags.

Alongside the flags, each channel keeps a max-hold record of the largest magnitude it has seen. A per-channel read-and-reset strobe returns the held value in the same cycle and empties the record on the next edge. Bus decoding and the converters that produce the samples sit outside this block.

Top module: `peak_mon`

## Requirements
- R1: After reset both flags, the interrupt and both records read zero.
- R2: A valid sample whose magnitude, taken in its upper 16 bits (bits 23:8), is strictly greater than the channel level sets that channel's flag on the next clock edge. An equal value does not set it.
- R3: Only bits 23:8 of the magnitude take part in the comparison. A sample of 0x28F5C2 against level 0x28F5 does not set the flag, and neither does 0x123456 against 0x1234.
- R4: A negative sample is rectified to its two's-complement magnitude. The most negative code 0x800000 gives 0x7FFFFF, so a record never has bit 23 set.
- R5: With level 0x0000, any magnitude of 0x000100 or more sets the flag. A magnitude of 0x0000FF does not.
- R6: A flag stays set until a status-read strobe is seen. After the strobe it is low from the next edge.
- R7: If a status read and a new exceed event on a channel fall in the same cycle, that channel's flag stays set.
- R8: The interrupt is high exactly while some channel has both its flag and its enable input high. It follows the enable inputs without a clock delay.
- R9: A record takes the magnitude of a valid sample that is greater than the stored value and otherwise holds. Samples presented while their valid strobe is low change neither record nor flag.
- R10: During a read-and-reset cycle the record output still shows the old value. From the next edge it reads zero.
- R11: If a read-and-reset and a valid sample fall in the same cycle, the record holds that sample's magnitude after the edge, even when it is smaller than the old value.
- R12: The two channels are independent. Activity on one leaves the other's flag and record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| v_smp | input | 24 | Voltage sample, signed |
| v_vld | input | 1 | Voltage sample valid |
| i_smp | input | 24 | Current sample, signed |
| i_vld | input | 1 | Current sample valid |
| v_lvl | input | 16 | Voltage peak level |
| i_lvl | input | 16 | Current peak level |
| v_irq_en | input | 1 | Voltage flag interrupt enable |
| i_irq_en | input | 1 | Current flag interrupt enable |
| stat_rd | input | 1 | Status-read strobe, clears both flags |
| v_rec_rd | input | 1 | Voltage record read-and-reset strobe |
| i_rec_rd | input | 1 | Current record read-and-reset strobe |
| v_flag | output | 1 | Voltage exceeded flag |
| i_flag | output | 1 | Current exceeded flag |
| irq | output | 1 | Combined enabled interrupt |
| v_rec | output | 24 | Voltage peak magnitude record |
| i_rec | output | 24 | Current peak magnitude record |

## Verification
The bench aims at the boundaries of the comparison. These are values equal in their upper sixteen bits but larger in the low byte, the full-scale code against its own level, and level zero against a magnitude below 0x100. A design that compared all 24 bits, or used greater-or-equal, would raise the flag in these cases. The most negative code is driven to catch a rectifier that wraps to 0x800000 and stores a huge record. Collisions are also driven: a clear in the same cycle as an exceed event, and a read-and-reset in the same cycle as a smaller sample. Wrong priority there shows up as a dropped flag, or as a record reading zero or the stale value.

// File: rtl/peak_mon_pkg.sv
package peak_mon_pkg;
  localparam int NCH  = 2;
  localparam int CH_V = 0;
  localparam int CH_I = 1;
endpackage

// File: rtl/peak_rectify.sv
module peak_rectify #(
  parameter int W = 24
) (
  input  logic [W-1:0] smp,
  output logic [W-1:0] mag
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (!smp[W-1])           mag = smp;
    else if (smp == MOST_NEG) mag = MOST_POS;
    else                      mag = -smp;
  end
endmodule

// File: rtl/peak_flag.sv
module peak_flag #(
  parameter int W  = 24,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [W-1:0]  mag,
  input  logic [LW-1:0] lvl,
  input  logic          clr,
  output logic          flag
);
  logic over;
  logic flag_en;
  logic flag_nxt;
  logic flag_q;

  always_comb begin
    over     = vld && (mag[W-1 -: LW] > lvl);
    flag_en  = over || clr;
    flag_nxt = over;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_nxt;
  end

  assign flag = flag_q;
endmodule

// File: rtl/peak_hold.sv
module peak_hold #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld,
  input  logic [W-1:0] mag,
  input  logic         rd,
  output logic [W-1:0] rec
);
  logic         bigger;
  logic         rec_en;
  logic [W-1:0] rec_nxt;
  logic [W-1:0] rec_q;

  always_comb begin
    bigger = vld && (mag > rec_q);
    rec_en = rd || bigger;
    if (rd) rec_nxt = vld ? mag : '0;
    else    rec_nxt = mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rec_q <= '0;
    else if (rec_en) rec_q <= rec_nxt;
  end

  assign rec = rec_q;
endmodule

// File: rtl/peak_mon.sv
module peak_mon
  import peak_mon_pkg::*;
#(
  parameter int SMP_W = 24,
  parameter int LVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] v_smp,
  input  logic             v_vld,
  input  logic [SMP_W-1:0] i_smp,
  input  logic             i_vld,
  input  logic [LVL_W-1:0] v_lvl,
  input  logic [LVL_W-1:0] i_lvl,
  input  logic             v_irq_en,
  input  logic             i_irq_en,
  input  logic             stat_rd,
  input  logic             v_rec_rd,
  input  logic             i_rec_rd,
  output logic             v_flag,
  output logic             i_flag,
  output logic             irq,
  output logic [SMP_W-1:0] v_rec,
  output logic [SMP_W-1:0] i_rec
);
  logic [SMP_W-1:0] smp_a [NCH];
  logic [LVL_W-1:0] lvl_a [NCH];
  logic [SMP_W-1:0] mag_a [NCH];
  logic [SMP_W-1:0] rec_a [NCH];
  logic [NCH-1:0]   vld_v;
  logic [NCH-1:0]   rd_v;
  logic [NCH-1:0]   en_v;
  logic [NCH-1:0]   flag_v;

  always_comb begin
    smp_a[CH_V] = v_smp;
    smp_a[CH_I] = i_smp;
    lvl_a[CH_V] = v_lvl;
    lvl_a[CH_I] = i_lvl;
    vld_v[CH_V] = v_vld;
    vld_v[CH_I] = i_vld;
    rd_v[CH_V]  = v_rec_rd;
    rd_v[CH_I]  = i_rec_rd;
    en_v[CH_V]  = v_irq_en;
    en_v[CH_I]  = i_irq_en;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    peak_rectify #(.W(SMP_W)) u_rect (
      .smp (smp_a[c]),
      .mag (mag_a[c])
    );
    peak_flag #(.W(SMP_W), .LW(LVL_W)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (vld_v[c]),
      .mag   (mag_a[c]),
      .lvl   (lvl_a[c]),
      .clr   (stat_rd),
      .flag  (flag_v[c])
    );
    peak_hold #(.W(SMP_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (vld_v[c]),
      .mag   (mag_a[c]),
      .rd    (rd_v[c]),
      .rec   (rec_a[c])
    );
  end

  assign irq    = |(flag_v & en_v);
  assign v_flag = flag_v[CH_V];
  assign i_flag = flag_v[CH_I];
  assign v_rec  = rec_a[CH_V];
  assign i_rec  = rec_a[CH_I];
endmodule

// File: rtl/peak_mon_chk.sv
module peak_mon_chk #(
  parameter int SMP_W = 24,
  parameter int LVL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SMP_W-1:0] v_smp,
  input logic             v_vld,
  input logic [SMP_W-1:0] i_smp,
  input logic             i_vld,
  input logic [LVL_W-1:0] v_lvl,
  input logic [LVL_W-1:0] i_lvl,
  input logic             v_irq_en,
  input logic             i_irq_en,
  input logic             stat_rd,
  input logic             v_rec_rd,
  input logic             i_rec_rd,
  input logic             v_flag,
  input logic             i_flag,
  input logic             irq,
  input logic [SMP_W-1:0] v_rec,
  input logic [SMP_W-1:0] i_rec
);
  function automatic logic [LVL_W-1:0] top_of(input logic [SMP_W-1:0] s);
    logic [SMP_W:0] wide;
    wide = s[SMP_W-1] ? ({1'b0, ~s} + 1'b1) : {1'b0, s};
    if (wide[SMP_W]) wide = wide - 1'b1;
    if (wide[SMP_W-1]) wide = wide - 1'b1;
    return wide[SMP_W-1 -: LVL_W];
  endfunction

  AST_V_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (v_vld && top_of(v_smp) > v_lvl) |=> v_flag);            // R2
  AST_I_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (i_vld && top_of(i_smp) > i_lvl) |=> i_flag);            // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (v_flag && !stat_rd) |=> v_flag);                        // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !v_vld) |=> !v_flag);                        // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((!v_flag && !i_flag) || (!v_irq_en && !i_irq_en)) |-> !irq); // R8
  AST_REC_NO_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    !v_rec[SMP_W-1] && !i_rec[SMP_W-1]);                     // R4
  AST_REC_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (v_rec_rd && !v_vld) |=> (v_rec == '0));                 // R10
  AST_REC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    !i_rec_rd |=> (i_rec >= $past(i_rec)));                  // R9
  AST_REC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!v_vld && !v_rec_rd) |=> $stable(v_rec));               // R9
endmodule

bind peak_mon peak_mon_chk #(.SMP_W(SMP_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .v_smp(v_smp), .v_vld(v_vld), .i_smp(i_smp),
  .i_vld(i_vld), .v_lvl(v_lvl), .i_lvl(i_lvl), .v_irq_en(v_irq_en),
  .i_irq_en(i_irq_en), .stat_rd(stat_rd), .v_rec_rd(v_rec_rd),
  .i_rec_rd(i_rec_rd), .v_flag(v_flag), .i_flag(i_flag), .irq(irq),
  .v_rec(v_rec), .i_rec(i_rec)
);

// File: tb/peak_mon_bench.sv
module peak_mon_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] v_smp, i_smp;
  logic        v_vld, i_vld;
  logic [15:0] v_lvl, i_lvl;
  logic        v_irq_en, i_irq_en, stat_rd, v_rec_rd, i_rec_rd;
  logic        v_flag, i_flag, irq;
  logic [23:0] v_rec, i_rec;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  peak_mon u_peak_mon (
    .clk(clk), .rst_n(rst_n), .v_smp(v_smp), .v_vld(v_vld), .i_smp(i_smp),
    .i_vld(i_vld), .v_lvl(v_lvl), .i_lvl(i_lvl), .v_irq_en(v_irq_en),
    .i_irq_en(i_irq_en), .stat_rd(stat_rd), .v_rec_rd(v_rec_rd),
    .i_rec_rd(i_rec_rd), .v_flag(v_flag), .i_flag(i_flag), .irq(irq),
    .v_rec(v_rec), .i_rec(i_rec)
  );

  // {sample, level, expected flag, expected record}
  localparam logic [64:0] VEC [10] = '{
    {24'h001234, 16'h0000, 1'b1, 24'h001234},
    {24'h0000FF, 16'h0000, 1'b0, 24'h0000FF},
    {24'h28F5C2, 16'h28F5, 1'b0, 24'h28F5C2},
    {24'h28F600, 16'h28F5, 1'b1, 24'h28F600},
    {24'hFFFFFF, 16'h0000, 1'b0, 24'h000001},
    {24'h800000, 16'h7FFF, 1'b0, 24'h7FFFFF},
    {24'h800000, 16'h7FFE, 1'b1, 24'h7FFFFF},
    {24'hD70A3E, 16'h28F4, 1'b1, 24'h28F5C2},
    {24'h123456, 16'h1234, 1'b0, 24'h123456},
    {24'hEDCBAA, 16'h1233, 1'b1, 24'h123456}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    v_vld = 0; i_vld = 0; stat_rd = 0; v_rec_rd = 0; i_rec_rd = 0;
  endtask

  task automatic wipe();
    stat_rd = 1; v_rec_rd = 1; i_rec_rd = 1; v_vld = 0; i_vld = 0;
    tick();
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; idle();
    v_smp = 0; i_smp = 0; v_lvl = 0; i_lvl = 0; v_irq_en = 0; i_irq_en = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 v_flag", v_flag, 0);
    chk("R1 i_flag", i_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 v_rec", v_rec, 0);
    chk("R1 i_rec", i_rec, 0);

    // Table walk: both channels see the same vector (R2 R3 R4 R5).
    for (int k = 0; k < 10; k++) begin
      wipe();
      v_smp = VEC[k][64:41]; i_smp = VEC[k][64:41];
      v_lvl = VEC[k][40:25]; i_lvl = VEC[k][40:25];
      v_vld = 1; i_vld = 1;
      tick();
      idle();
      chk("R2 R3 R5 v_flag table", v_flag, VEC[k][24]);
      chk("R2 R3 R5 i_flag table", i_flag, VEC[k][24]);
      chk("R4 R9 v_rec table", v_rec, VEC[k][23:0]);
      chk("R4 R9 i_rec table", i_rec, VEC[k][23:0]);
    end

    // R8: interrupt gating
    wipe();
    v_lvl = 16'h0100; i_lvl = 16'h0100;
    v_smp = 24'h020000; v_vld = 1;
    tick(); idle();
    chk("R12 i_flag untouched", i_flag, 0);
    chk("R12 i_rec untouched", i_rec, 0);
    chk("R8 irq disabled", irq, 0);
    i_irq_en = 1; #1;
    chk("R8 irq other enable", irq, 0);
    v_irq_en = 1; #1;
    chk("R8 irq enabled", irq, 1);
    v_irq_en = 0; #1;
    chk("R8 irq follows enable", irq, 0);

    // R6: sticky, then cleared
    v_smp = 24'h000010; v_vld = 1;
    tick(); tick(); idle();
    chk("R6 sticky", v_flag, 1);
    chk("R9 record holds", v_rec, 24'h020000);
    v_smp = 24'h7F0000; v_vld = 0;
    tick();
    chk("R9 invalid ignored rec", v_rec, 24'h020000);
    stat_rd = 1; tick(); idle();
    chk("R6 cleared", v_flag, 0);

    // R7: clear and exceed same cycle
    i_smp = 24'h050000; i_vld = 1; stat_rd = 1;
    tick(); idle();
    chk("R7 event wins", i_flag, 1);
    chk("R8 irq current", irq, 1);

    // R10: read-and-reset
    v_rec_rd = 1; #1;
    chk("R10 old value during read", v_rec, 24'h020000);
    tick(); idle();
    chk("R10 zero after read", v_rec, 0);

    // R11: read with smaller sample
    i_smp = 24'hFFFFF0; i_vld = 1; i_rec_rd = 1;
    tick(); idle();
    chk("R11 new sample kept", i_rec, 24'h000010);

    tick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule